// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block is the central arbiter of a shared bus whose device controllers are grouped by urgency. Each group drives one request line into the arbiter. Within a group, the controllers sit on a daisy chain that carries a single grant. The request line a controller uses sets its vertical level. Its place along the chain breaks ties inside that level: a controller nearer the arbiter sees the grant first.

At an arbitration point the arbiter takes a snapshot of the request lines and of the chain of the winning level. It then raises that level's grant. The grant travels down the chain, past every controller that does not want the bus, until the first controller that does want it absorbs it. That controller answers with an acknowledge, which announces that it will be the next master. The arbiter then withdraws the grant and records the owner. It waits while the new master paces its bus cycle with master-sync and the slave answers with slave-sync. Only when both syncs are low does the arbiter decide who owns the following cycle.

The handshake is modelled with one clock. The chain pass-through is evaluated inside the block, and the grant that reaches each controller is brought out on its own output.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every level grant, every device grant and `owner_valid` are 0.
- R2: When arbitration takes place, the grant goes to the asserted request line with the highest index (line 3 over 2, 2 over 1, 1 over 0). The level grant appears in the cycle after the requests are sampled.
- R3: Within the granted level L, the device grant goes to the lowest chain position p whose `want` bit `want[L*CHAIN+p]` is set. Position 0 is nearest the arbiter. Only `dev_grant[L*CHAIN+p]` is set.
- R4: At most one level grant and at most one device grant are active in any cycle.
- R5: With no request line asserted, the arbiter drives no grant.
- R6: A grant stays up until `bus_ack` is sampled. In the next cycle the grant is 0, `owner_valid` is 1 and `owner_id` equals L*CHAIN+p. It stays unchanged until the bus cycle ends.
- R7: No new grant is issued while `msync` or `ssync` is high, or while an acknowledged owner has not finished its cycle. Once `msync` and `ssync` are both low after the cycle, `owner_valid` returns to 0 and arbitration resumes.
- R8: Requests and `want` bits are sampled only at the arbitration point. Changes to them while a grant is up do not alter that grant.
- R9: If no controller in the granted level's chain wants the bus, the grant drops after one cycle with no owner recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | LEVELS | One request line per priority level; a higher index is more urgent |
| want | input | LEVELS*CHAIN | Per-controller bus wish, index level*CHAIN+position |
| bus_ack | input | 1 | Acknowledge from the controller that absorbed the grant |
| msync | input | 1 | Master-sync of the current bus master |
| ssync | input | 1 | Slave-sync of the addressed slave |
| lvl_grant | output | LEVELS | Grant driven into each level's chain |
| dev_grant | output | LEVELS*CHAIN | Grant as absorbed by each controller after pass-through |
| owner_valid | output | 1 | An acknowledged master owns or holds the bus |
| owner_id | output | $clog2(LEVELS*CHAIN) | Index of that master, level*CHAIN+position |

## Verification
On every cycle, the assertions check the following:
- one-hot grants, with a device grant only inside a granted level;
- no grant after an idle cycle with no requests, or while either sync is high;
- withdrawal of the grant on acknowledge;
- stability of the grant and of the owner index.

Which controller wins depends on the level and chain pattern, so only the bench's scenarios can show that choice. The same holds for ignoring request changes after sampling, for dropping a grant on an empty chain, and for resuming after the cycle ends.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int LEVELS = 4,
  parameter int CHAIN  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [LEVELS-1:0]                 bus_req,
  input  logic [LEVELS*CHAIN-1:0]           want,
  input  logic                              bus_ack,
  input  logic                              msync,
  input  logic                              ssync,
  output logic [LEVELS-1:0]                 lvl_grant,
  output logic [LEVELS*CHAIN-1:0]           dev_grant,
  output logic                              owner_valid,
  output logic [$clog2(LEVELS*CHAIN)-1:0]   owner_id
);
  localparam int LW  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PW  = (CHAIN > 1) ? $clog2(CHAIN) : 1;
  localparam int IDW = $clog2(LEVELS*CHAIN);

  typedef enum logic [1:0] {S_IDLE, S_GRANT, S_OWNED, S_CYCLE} st_t;
  st_t state;

  logic [LW-1:0]    win_lvl, lvl_q;
  logic             any_req;
  logic [CHAIN-1:0] chain_q, take;
  logic [CHAIN:0]   pass;
  logic [PW-1:0]    take_pos;
  logic             taker;

  always_comb begin
    win_lvl = '0;
    for (int l = 0; l < LEVELS; l++)
      if (bus_req[l]) win_lvl = LW'(l);
  end
  assign any_req = |bus_req;

  always_comb begin
    pass[0]  = 1'b1;
    take_pos = '0;
    for (int p = 0; p < CHAIN; p++) begin
      take[p]   = pass[p] & chain_q[p];
      pass[p+1] = pass[p] & ~chain_q[p];
      if (take[p]) take_pos = PW'(p);
    end
  end
  assign taker = ~pass[CHAIN];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    wire on = (state == S_GRANT) && (lvl_q == LW'(l));
    assign lvl_grant[l] = on;
    assign dev_grant[l*CHAIN +: CHAIN] = on ? take : '0;
  end

  assign owner_valid = (state == S_OWNED) || (state == S_CYCLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lvl_q    <= '0;
      chain_q  <= '0;
      owner_id <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (any_req && !msync && !ssync) begin
            lvl_q   <= win_lvl;
            chain_q <= want[int'(win_lvl)*CHAIN +: CHAIN];
            state   <= S_GRANT;
          end
        S_GRANT:
          if (!taker) state <= S_IDLE;
          else if (bus_ack) begin
            owner_id <= IDW'(int'(lvl_q)*CHAIN + int'(take_pos));
            state    <= S_OWNED;
          end
        S_OWNED:
          if (msync) state <= S_CYCLE;
        default:
          if (!msync && !ssync) state <= S_IDLE;
      endcase
    end
  end

  a_r4_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_grant));
  a_r4_one_dev: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));
  a_r3_dev_inside_level: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_grant) |-> (|lvl_grant));
  a_r5_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|lvl_grant) && !owner_valid && !(|bus_req)) |=> !(|lvl_grant));
  a_r7_busy_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|lvl_grant) && (msync || ssync)) |=> !(|lvl_grant));
  a_r6_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_grant) && bus_ack) |=> (!(|lvl_grant) && owner_valid));
  a_r6_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && $past(owner_valid)) |-> $stable(owner_id));
  a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dev_grant) && !bus_ack) |=> ($stable(lvl_grant) && $stable(dev_grant)));
endmodule

// File: tb/sim_prio_bus_arbiter.sv
module sim_prio_bus_arbiter;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_req = 0;
  logic [15:0] want = 0;
  logic bus_ack = 0, msync = 0, ssync = 0;
  logic [3:0] lvl_grant;
  logic [15:0] dev_grant;
  logic owner_valid;
  logic [3:0] owner_id;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  prio_bus_arbiter #(.LEVELS(4), .CHAIN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .want(want),
    .bus_ack(bus_ack), .msync(msync), .ssync(ssync),
    .lvl_grant(lvl_grant), .dev_grant(dev_grant),
    .owner_valid(owner_valid), .owner_id(owner_id));

  // {req[4], want[16], expected level grant[4], expected owner id[4]}
  localparam logic [27:0] VEC [7] = '{
    28'h1_000F_1_0, 28'hF_FFFF_8_C, 28'h6_0CF0_4_A, 28'h3_0080_2_7,
    28'h9_8001_8_F, 28'h5_0600_4_9, 28'hC_3000_8_C };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_cycle();
    msync = 1; step();
    msync = 0; ssync = 1; step();
    check("R7 no grant while ssync high", 32'(lvl_grant), 0);
    check("R7 owner kept during cycle", 32'(owner_valid), 1);
    ssync = 0; step();
    check("R7 owner released after cycle", 32'(owner_valid), 0);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bus_req = 4'hF; want = 16'hFFFF;
    step(); step();
    check("R1 level grant in reset", 32'(lvl_grant), 0);
    check("R1 device grant in reset", 32'(dev_grant), 0);
    check("R1 owner in reset", 32'(owner_valid), 0);
    bus_req = 0; want = 0;
    rst_n = 1; step();
    check("R1 first cycle after reset", 32'(lvl_grant), 0);

    for (int i = 0; i < 7; i++) begin
      logic [27:0] v = VEC[i];
      bus_req = v[27:24]; want = v[23:8];
      step();
      check($sformatf("R2 level winner vec%0d", i), 32'(lvl_grant), 32'(v[7:4]));
      check($sformatf("R3 chain winner vec%0d", i), 32'(dev_grant), 32'(16'h1 << v[3:0]));
      bus_req = 0; want = ~v[23:8];
      step();
      check($sformatf("R8 level grant held vec%0d", i), 32'(lvl_grant), 32'(v[7:4]));
      check($sformatf("R8 device grant held vec%0d", i), 32'(dev_grant), 32'(16'h1 << v[3:0]));
      bus_ack = 1; want = 0; step();
      bus_ack = 0;
      check($sformatf("R6 grant withdrawn vec%0d", i), 32'(lvl_grant), 0);
      check($sformatf("R6 owner valid vec%0d", i), 32'(owner_valid), 1);
      check($sformatf("R6 owner id vec%0d", i), 32'(owner_id), 32'(v[3:0]));
      finish_cycle();
    end

    want = 16'hFFFF; bus_req = 0;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R5 no request no grant", 32'(lvl_grant), 0);
    end

    bus_req = 4'b0010; want = 16'h00F0; msync = 1;
    step(); step();
    check("R7 no grant while msync high", 32'(lvl_grant), 0);
    msync = 0; ssync = 1; step();
    check("R7 no grant while ssync high idle", 32'(lvl_grant), 0);
    ssync = 0; step(); step();
    check("R7 grant resumes after syncs low", 32'(lvl_grant), 32'h2);
    check("R3 position 0 wins", 32'(dev_grant), 32'h10);
    bus_req = 0; bus_ack = 1; step();
    bus_ack = 0;
    check("R6 owner id level1 pos0", 32'(owner_id), 4);
    bus_req = 4'b1000; step();
    check("R7 no grant for pending owner", 32'(lvl_grant), 0);
    bus_req = 0;
    finish_cycle();

    bus_req = 4'b0100; want = 16'h000F; step();
    check("R9 grant raised on empty chain", 32'(lvl_grant), 32'h4);
    check("R9 no device absorbs", 32'(dev_grant), 0);
    bus_req = 0; step();
    check("R9 grant dropped", 32'(lvl_grant), 0);
    check("R9 no owner recorded", 32'(owner_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule